// File: doc/BRIEF.md
# Register-Field Select and Bus Strobe Decoder

This block is hardwired control logic for a processor with a 32-entry register file on one internal bus. It keeps the current instruction word in a register that loads on a strobe. From that word it produces two sets of one-hot outputs.

The first set comes from a single shared 5-to-32 decoder. Three one-hot field enables from the sequencer choose which register-specifier field feeds that decoder. Two qualifiers then split the decoded line into separate strobes. One strobe gates a register onto the bus, and the other loads a register from the bus. The second set comes from a separate 5-to-32 decoder on the opcode field, which gives one line per instruction.

Every output is combinational from the stored instruction word and the current enable and qualifier inputs. The register file and the ALU are outside this block.

Top module: `regsel_decode`

## Requirements
- R1: The instruction register clears to zero while `rst_n` is low. On a rising clock edge with `ir_load` high it captures `ir_in`. With `ir_load` low it keeps its value.
- R2: `op_line` is one-hot, with bit k set exactly when stored bits 31..27 equal k. Code 0 is no-op, 1 memory read, 2 relative memory read, 3 memory write, 4 relative memory write, 5 address load and 31 halt. After reset only bit 0 is set.
- R3: With `sel_a` high, the shared decoder input is stored bits 26..22.
- R4: With `sel_b` high, the shared decoder input is stored bits 21..17.
- R5: With `sel_c` high, the shared decoder input is stored bits 16..12.
- R6: At most one of `sel_a`, `sel_b` and `sel_c` may be high in a cycle, and a property flags any cycle that breaks this rule. When none of them is high, `reg_drive` and `reg_load` are all zero.
- R7: `reg_drive` equals the decoded one-hot line when `drive_en` is high, and is zero otherwise.
- R8: `reg_load` equals the decoded one-hot line when `load_en` is high, and is zero otherwise.
- R9: When `drive_en` and `load_en` are both high, `reg_drive` and `reg_load` carry the same single bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_load | input | 1 | Load strobe for the instruction register |
| ir_in | input | 32 | Instruction word to capture |
| sel_a | input | 1 | Select the first register field (bits 26..22) |
| sel_b | input | 1 | Select the second register field (bits 21..17) |
| sel_c | input | 1 | Select the third register field (bits 16..12) |
| drive_en | input | 1 | Qualify the decoded line as a bus-drive gate |
| load_en | input | 1 | Qualify the decoded line as a bus-load strobe |
| reg_drive | output | 32 | Per-register bus-drive gates |
| reg_load | output | 32 | Per-register load strobes |
| op_line | output | 32 | One-hot opcode lines |

## Verification
A word presented with `ir_load` reaches the outputs at the rising edge that captures it. The bench therefore compares at the falling edge after that rising edge. Enable and qualifier changes have no register on their path and take effect in the same cycle. The bench drives them just after a falling edge, and its cycle-accurate model judges them at the next falling edge against the instruction word it holds at that moment. Because of this, a held word (R1) and a freshly switched field select are both judged against the correct stored value.

// File: rtl/regsel_pkg.sv
package regsel_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned SPEC_W = 5;

    typedef enum logic [SPEC_W-1:0] {
        OPC_IDLE       = 5'd0,
        OPC_MEMRD      = 5'd1,
        OPC_MEMRD_REL  = 5'd2,
        OPC_MEMWR      = 5'd3,
        OPC_MEMWR_REL  = 5'd4,
        OPC_ADDR       = 5'd5,
        OPC_HALT       = 5'd31
    } opcode_e;

endpackage

// File: rtl/ir_hold.sv
module ir_hold #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] word;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.word = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.word;

    a_r1_keep_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));
    a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(din)));

endmodule

// File: rtl/field_pick.sv
module field_pick #(
    parameter int unsigned FW    = 5,
    parameter int unsigned NSRC  = 3
) (
    input  logic [NSRC-1:0]    pick,
    input  logic [NSRC*FW-1:0] fields,
    output logic [FW-1:0]      code,
    output logic               any
);
    always_comb begin
        code = '0;
        for (int k = 0; k < NSRC; k++) begin
            code = code | (fields[k*FW +: FW] & {FW{pick[k]}});
        end
        any = |pick;
    end
endmodule

// File: rtl/onehot_dec.sv
module onehot_dec #(
    parameter int unsigned IN_W = 5,
    localparam int unsigned OUT_N = 1 << IN_W
) (
    input  logic             en,
    input  logic [IN_W-1:0]  code,
    output logic [OUT_N-1:0] lines
);
    for (genvar i = 0; i < OUT_N; i++) begin : g_line
        assign lines[i] = en && (code == IN_W'(i));
    end
endmodule

// File: rtl/regsel_decode.sv
module regsel_decode #(
    parameter int unsigned IR_W  = regsel_pkg::WORD_W,
    parameter int unsigned FLD_W = regsel_pkg::SPEC_W,
    localparam int unsigned NREG  = 1 << FLD_W,
    localparam int unsigned OPC_LSB = IR_W - FLD_W,
    localparam int unsigned A_LSB   = OPC_LSB - FLD_W,
    localparam int unsigned B_LSB   = A_LSB - FLD_W,
    localparam int unsigned C_LSB   = B_LSB - FLD_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ir_load,
    input  logic [IR_W-1:0] ir_in,
    input  logic            sel_a,
    input  logic            sel_b,
    input  logic            sel_c,
    input  logic            drive_en,
    input  logic            load_en,
    output logic [NREG-1:0] reg_drive,
    output logic [NREG-1:0] reg_load,
    output logic [NREG-1:0] op_line
);
    logic [IR_W-1:0]  ir_q;
    logic [FLD_W-1:0] spec_code;
    logic             spec_any;
    logic [NREG-1:0]  spec_lines;

    ir_hold #(.W(IR_W)) u_ir (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ir_load),
        .din   (ir_in),
        .q     (ir_q)
    );

    field_pick #(.FW(FLD_W), .NSRC(3)) u_pick (
        .pick   ({sel_c, sel_b, sel_a}),
        .fields ({ir_q[C_LSB +: FLD_W], ir_q[B_LSB +: FLD_W], ir_q[A_LSB +: FLD_W]}),
        .code   (spec_code),
        .any    (spec_any)
    );

    onehot_dec #(.IN_W(FLD_W)) u_spec_dec (
        .en    (spec_any),
        .code  (spec_code),
        .lines (spec_lines)
    );

    onehot_dec #(.IN_W(FLD_W)) u_opc_dec (
        .en    (1'b1),
        .code  (ir_q[OPC_LSB +: FLD_W]),
        .lines (op_line)
    );

    assign reg_drive = spec_lines & {NREG{drive_en}};
    assign reg_load  = spec_lines & {NREG{load_en}};

    if (C_LSB > 0) begin : g_low
        logic unused_low_bits;
        assign unused_low_bits = ^ir_q[C_LSB-1:0];
    end

    // Input contract: the sequencer raises at most one field enable.
    a_r6_enables_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_a, sel_b, sel_c}));
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_a || sel_b || sel_c) |-> (reg_drive == '0 && reg_load == '0));
    a_r2_opcode_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(op_line));
    a_r7_drive_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_drive));
    a_r8_load_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |-> (reg_load == '0));
    a_r9_same_target: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en && load_en) |-> (reg_drive == reg_load));

endmodule

// File: tb/tb_regsel_decode.sv
`timescale 1ns/1ps
module tb_regsel_decode;
    import regsel_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ir_load = 1'b0;
    logic [31:0] ir_in = '0;
    logic        sel_a = 1'b0, sel_b = 1'b0, sel_c = 1'b0;
    logic        drive_en = 1'b0, load_en = 1'b0;
    logic [31:0] reg_drive, reg_load, op_line;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    int unsigned cyc = 0;
    bit          done = 1'b0;
    logic [31:0] m_ir = '0;

    always #4 clk = ~clk;

    regsel_decode dut (
        .clk(clk), .rst_n(rst_n), .ir_load(ir_load), .ir_in(ir_in),
        .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c),
        .drive_en(drive_en), .load_en(load_en),
        .reg_drive(reg_drive), .reg_load(reg_load), .op_line(op_line)
    );

    // Behavioural model of the stored word (R1).
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_ir = '0;
        else if (ir_load) m_ir = ir_in;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic string sel_tag();
        if (sel_a) return "R3";
        if (sel_b) return "R4";
        if (sel_c) return "R5";
        return "R6";
    endfunction

    always @(negedge clk) begin
        int code;
        logic [31:0] line;
        code = sel_a ? int'(m_ir[26:22]) : sel_b ? int'(m_ir[21:17]) :
               sel_c ? int'(m_ir[16:12]) : -1;
        line = (code < 0) ? 32'h0 : (32'h1 << code);
        if (!done) begin
            chk("R2 opcode lines from word held per R1", op_line, 32'h1 << m_ir[31:27]);
            chk({sel_tag(), drive_en ? " R7 drive" : " R7 drive off"},
                reg_drive, drive_en ? line : 32'h0);
            chk({sel_tag(), (drive_en && load_en) ? " R9 load" : " R8 load"},
                reg_load, load_en ? line : 32'h0);
        end
    end

    task automatic step(input bit ld, input logic [31:0] w, input bit a, input bit b,
                        input bit c, input bit dr, input bit lo);
        @(negedge clk);
        #1;
        ir_load = ld; ir_in = w; sel_a = a; sel_b = b; sel_c = c;
        drive_en = dr; load_en = lo;
    endtask

    function automatic logic [31:0] mk(input int op, input int ra, input int rb, input int rc);
        return {5'(op), 5'(ra), 5'(rb), 5'(rc), 12'hA5C};
    endfunction

    task automatic finish_run();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset leaves the no-op line alone
        chk("R2 reset no-op line", op_line, 32'h1);
        chk("R6 reset drive quiet", reg_drive, 32'h0);
        #1 rst_n = 1'b1;

        // R3 R4 R5 with field extremes 0 and 31
        step(1, mk(OPC_MEMWR, 7, 0, 31), 0, 0, 0, 0, 0);
        step(0, '0, 1, 0, 0, 1, 0);
        step(0, '0, 0, 1, 0, 0, 1);
        step(0, '0, 0, 0, 1, 1, 1);   // R9 both qualifiers
        step(0, '0, 0, 0, 0, 1, 1);   // R6 no field selected
        // R1 hold: new word offered without strobe
        step(0, mk(OPC_HALT, 1, 2, 3), 1, 0, 0, 1, 0);
        step(0, mk(OPC_HALT, 1, 2, 3), 0, 0, 1, 0, 1);
        step(1, mk(OPC_HALT, 1, 2, 3), 0, 1, 0, 1, 1);
        step(0, '0, 0, 1, 0, 1, 1);
        // R7 R8 qualifiers low while a field is selected
        step(0, '0, 1, 0, 0, 0, 0);
        // R2 every opcode
        for (int op = 0; op < 32; op++) begin
            step(1, mk(op, op, 31 - op, op ^ 5), op % 3 == 0, op % 3 == 1, op % 3 == 2,
                 op[0], op[1]);
        end
        // mixed patterns, enables kept one-hot or idle (R6 contract)
        for (int i = 0; i < 300; i++) begin
            int k;
            k = $urandom % 4;
            step($urandom % 2, $urandom, k == 1, k == 2, k == 3, $urandom % 2, $urandom % 2);
        end
        step(0, '0, 0, 0, 0, 0, 0);
        @(negedge clk);
        @(negedge clk);
        #1 finish_run();
    end
endmodule